// File: doc/BRIEF.md
# Pointer Prefix Address Decoder

This block sits in the instruction decode path of an 8-bit accumulator processor. It watches the opcode stream and recognises a one-byte prefix taken from an unused opcode slot. When the prefix comes before an instruction with a zero-page or absolute operand, the block treats that operand as the address of a 16-bit pointer. It then reads the pointer through its own byte-wide memory port and reports the pointer's contents as the effective address.

Without the prefix, every opcode is classified and addressed exactly as in the base instruction set. If the prefix comes before an implied instruction, or before one that already has an indirect encoding, the prefix is dropped quietly and no fault is raised.

Bytes reach the block through a fetch strobe. The opcode comes first and is followed by its operand bytes. While the block reads a pointer it raises `ptr_busy` so that the surrounding core holds off further fetches.

Top module: `ptr_prefix_decoder`

## Requirements
- R1: After reset, `prefix_pending`, `indirect`, `mem_rd`, `ptr_busy` and `ea_valid` are 0, and `mode` is 0 (implied class).
- R2: An opcode byte equal to `PREFIX_OP` (default 0x0B, an unused slot) sets `prefix_pending` in the next cycle. No other opcode sets it.
- R3: The next non-prefix opcode clears `prefix_pending`, whether or not the prefix changed that opcode.
- R4: Zero-page class (`mode`=1): low nibble 7, or low nibble 4/5/6 with bit 4 clear, or 0x14. One operand byte follows. One cycle after it, `ea_valid` pulses with `ea` = {0x00, operand}.
- R5: Absolute class (`mode`=2): low nibble C/D/E with bit 4 clear, except 0x6C, plus 0x1C and 0x9C. Two operand bytes follow, low byte first. One cycle after the second byte, `ea_valid` pulses with `ea` = {high, low}.
- R6: Prefix plus a zero-page opcode gives `mode`=3 and `indirect`=1. The block reads pointer byte P, then byte (P+1) mod 256 in page zero. It reports `ea` = {second byte, first byte}.
- R7: Prefix plus an absolute opcode gives `mode`=4 and `indirect`=1. The block reads address A, then A+1 with a full 16-bit carry. It reports `ea` = {second byte, first byte}.
- R8: An indirect form makes exactly two memory reads, and `ea_valid` comes three cycles after the last operand byte. A direct form makes no reads, and `ea_valid` comes after one cycle.
- R9: These classes ignore the prefix: they give `indirect`=0, no memory reads and no `ea_valid`. Native indirect (`mode`=5) covers low nibble 1, low nibble 2 with bit 4 set, 0x6C and 0x7C. Implied (`mode`=0) covers low nibble 8 or A. Every other opcode is `mode`=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Strobe: `fetch_byte` holds an opcode or operand byte |
| fetch_byte | input | 8 | Fetched instruction byte |
| mode | output | 3 | Decoded addressing class of the last instruction |
| indirect | output | 1 | Last instruction was turned into a pointer form |
| prefix_pending | output | 1 | Prefix seen, next instruction not yet decoded |
| ptr_busy | output | 1 | Pointer read in progress; hold off fetches |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| ea_valid | output | 1 | One-cycle pulse: `ea` holds a new effective address |
| ea | output | 16 | Effective address |

## Verification
The assertions assume that `fetch_valid` stays low while `ptr_busy` is high. They also assume that each opcode is followed by exactly as many operand bytes as its class takes, and that memory answers in the same cycle as the read. The stimulus sends each instruction as a prefix (if any), the opcode and its operand bytes, and then waits for the pointer reads to finish before the next byte. Memory data is a pure function of the address, so every expected pointer value can be worked out ahead of time.

// File: rtl/ptr_prefix_decoder.sv
module ptr_prefix_decoder #(
  parameter logic [7:0] PREFIX_OP = 8'h0B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_valid,
  input  logic [7:0]  fetch_byte,
  output logic [2:0]  mode,
  output logic        indirect,
  output logic        prefix_pending,
  output logic        ptr_busy,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        ea_valid,
  output logic [15:0] ea
);

  localparam logic [2:0] M_IMPL = 3'd0;
  localparam logic [2:0] M_ZP   = 3'd1;
  localparam logic [2:0] M_ABS  = 3'd2;
  localparam logic [2:0] M_ZPI  = 3'd3;
  localparam logic [2:0] M_ABSI = 3'd4;
  localparam logic [2:0] M_NAT  = 3'd5;
  localparam logic [2:0] M_OTH  = 3'd6;

  typedef enum logic [2:0] {S_OP, S_LO, S_HI, S_PLO, S_PHI} st_t;
  st_t st;

  logic [7:0]  lo_q, ptr_lo_q;
  logic [15:0] ptr_q;
  logic [3:0]  nib;
  logic        is_pfx, is_zp, is_abs, is_nat, is_impl;
  logic [2:0]  cls;

  assign nib     = fetch_byte[3:0];
  assign is_pfx  = fetch_byte == PREFIX_OP;
  assign is_zp   = (nib == 4'h7) || (!fetch_byte[4] && (nib == 4'h4 || nib == 4'h5 || nib == 4'h6))
                   || (fetch_byte == 8'h14);
  assign is_abs  = (!fetch_byte[4] && (nib == 4'hC || nib == 4'hD || nib == 4'hE) && fetch_byte != 8'h6C)
                   || (fetch_byte == 8'h1C) || (fetch_byte == 8'h9C);
  assign is_nat  = (nib == 4'h1) || (fetch_byte[4] && nib == 4'h2)
                   || (fetch_byte == 8'h6C) || (fetch_byte == 8'h7C);
  assign is_impl = (nib == 4'h8) || (nib == 4'hA);

  always_comb begin
    if (is_zp)        cls = prefix_pending ? M_ZPI : M_ZP;
    else if (is_abs)  cls = prefix_pending ? M_ABSI : M_ABS;
    else if (is_nat)  cls = M_NAT;
    else if (is_impl) cls = M_IMPL;
    else              cls = M_OTH;
  end

  assign ptr_busy = (st == S_PLO) || (st == S_PHI);
  assign mem_rd   = ptr_busy;
  assign mem_addr = (st != S_PHI) ? ptr_q :
                    (mode == M_ZPI) ? {8'h00, ptr_q[7:0] + 8'h01} : ptr_q + 16'h0001;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= S_OP;
      mode           <= M_IMPL;
      indirect       <= 1'b0;
      prefix_pending <= 1'b0;
      ea_valid       <= 1'b0;
      ea             <= 16'h0000;
      lo_q           <= 8'h00;
      ptr_lo_q       <= 8'h00;
      ptr_q          <= 16'h0000;
    end else begin
      ea_valid <= 1'b0;
      case (st)
        S_OP: if (fetch_valid) begin
          if (is_pfx) prefix_pending <= 1'b1;
          else begin
            prefix_pending <= 1'b0;
            mode           <= cls;
            indirect       <= (cls == M_ZPI) || (cls == M_ABSI);
            if (is_zp || is_abs) st <= S_LO;
          end
        end
        S_LO: if (fetch_valid) begin
          lo_q <= fetch_byte;
          if (mode == M_ZP) begin
            ea       <= {8'h00, fetch_byte};
            ea_valid <= 1'b1;
            st       <= S_OP;
          end else if (mode == M_ZPI) begin
            ptr_q <= {8'h00, fetch_byte};
            st    <= S_PLO;
          end else st <= S_HI;
        end
        S_HI: if (fetch_valid) begin
          if (mode == M_ABS) begin
            ea       <= {fetch_byte, lo_q};
            ea_valid <= 1'b1;
            st       <= S_OP;
          end else begin
            ptr_q <= {fetch_byte, lo_q};
            st    <= S_PLO;
          end
        end
        S_PLO: begin
          ptr_lo_q <= mem_rdata;
          st       <= S_PHI;
        end
        S_PHI: begin
          ea       <= {mem_rdata, ptr_lo_q};
          ea_valid <= 1'b1;
          st       <= S_OP;
        end
        default: st <= S_OP;
      endcase
    end
  end

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && st == S_OP && fetch_byte == PREFIX_OP) |=> prefix_pending);
  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && st == S_OP && fetch_byte != PREFIX_OP) |=> !prefix_pending);
  // R8
  rd_only_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> indirect);
  // R6
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mode == M_ZPI) |-> mem_addr[15:8] == 8'h00);
  // R7
  abs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PHI && mode == M_ABSI) |-> mem_addr == $past(mem_addr) + 16'h0001);
  // R8
  two_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && indirect) |-> ($past(mem_rd) && $past(mem_rd, 2) && !$past(mem_rd, 3)));
  // R8
  direct_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !indirect) |-> !$past(mem_rd));
  // R9
  nat_no_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NAT || mode == M_IMPL || mode == M_OTH) |-> (!indirect && !mem_rd && !ea_valid));

endmodule

// File: tb/ptr_prefix_decoder_bench.sv
module ptr_prefix_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PFX = 8'h0B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [7:0]  fetch_byte = 8'h00;
  logic [2:0]  mode;
  logic        indirect, prefix_pending, ptr_busy, mem_rd, ea_valid;
  logic [15:0] mem_addr, ea;
  logic [7:0]  mem_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [7:0] md(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = md(mem_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_prefix_decoder #(.PREFIX_OP(PFX)) u_ptr_prefix_decoder (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .mode(mode), .indirect(indirect), .prefix_pending(prefix_pending), .ptr_busy(ptr_busy),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ea_valid(ea_valid), .ea(ea));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_byte  = b;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic run_addr(input string tag, input bit pfx, input logic [7:0] op,
                          input int nops, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [2:0] exp_mode, input logic [15:0] exp_ea);
    int reads = 0;
    int lat = 0;
    logic [15:0] got = 16'h0;
    if (pfx) begin
      send(PFX);
      chk({tag, " R2 pending set"}, prefix_pending, 1);
    end
    send(op);
    chk({tag, " R3 pending clear"}, prefix_pending, 0);
    chk({tag, " mode"}, mode, exp_mode);
    send(b0);
    if (nops == 2) send(b1);
    for (int i = 1; i <= 6; i++) begin
      if (mem_rd) reads++;
      if (ea_valid && lat == 0) begin lat = i; got = ea; end
      if (i < 6) @(negedge clk);
    end
    chk({tag, " ea"}, got, exp_ea);
    chk({tag, " indirect"}, indirect, pfx);
    chk({tag, " R8 reads"}, reads, pfx ? 2 : 0);
    chk({tag, " R8 latency"}, lat, pfx ? 3 : 1);
  endtask

  task automatic run_noaddr(input string tag, input bit pfx, input logic [7:0] op,
                            input logic [2:0] exp_mode);
    int acts = 0;
    if (pfx) send(PFX);
    send(op);
    chk({tag, " R9 mode"}, mode, exp_mode);
    chk({tag, " R9 indirect"}, indirect, 0);
    chk({tag, " R3 pending clear"}, prefix_pending, 0);
    for (int i = 0; i < 4; i++) begin
      if (mem_rd || ea_valid) acts++;
      @(negedge clk);
    end
    chk({tag, " R9 no reads/ea"}, acts, 0);
  endtask

  task automatic t_reset;
    chk("R1 pending", prefix_pending, 0);
    chk("R1 indirect", indirect, 0);
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 busy", ptr_busy, 0);
    chk("R1 ea_valid", ea_valid, 0);
    chk("R1 mode", mode, 0);
  endtask

  task automatic t_zero_page;
    run_addr("R4 TSB zp", 0, 8'h04, 1, 8'h37, 8'h00, 3'd1, 16'h0037);
    run_addr("R6 TSB (zp)", 1, 8'h04, 1, 8'h37, 8'h00, 3'd3, {md(16'h0038), md(16'h0037)});
    run_addr("R6 TRB (zp)", 1, 8'h14, 1, 8'h80, 8'h00, 3'd3, {md(16'h0081), md(16'h0080)});
    run_addr("R6 BIT (zp) wrap", 1, 8'h24, 1, 8'hFF, 8'h00, 3'd3, {md(16'h0000), md(16'h00FF)});
    run_addr("R6 INC (zp)", 1, 8'hE6, 1, 8'h10, 8'h00, 3'd3, {md(16'h0011), md(16'h0010)});
  endtask

  task automatic t_absolute;
    run_addr("R5 INC abs", 0, 8'hEE, 2, 8'h34, 8'h12, 3'd2, 16'h1234);
    run_addr("R5 TRB abs", 0, 8'h1C, 2, 8'hCD, 8'hAB, 3'd2, 16'hABCD);
    run_addr("R7 TRB (abs) carry", 1, 8'h1C, 2, 8'hFF, 8'h12, 3'd4, {md(16'h1300), md(16'h12FF)});
    run_addr("R7 TSB (abs)", 1, 8'h0C, 2, 8'h00, 8'h40, 3'd4, {md(16'h4001), md(16'h4000)});
  endtask

  task automatic t_double_prefix;
    send(PFX);
    run_addr("R2 double prefix", 1, 8'h05, 1, 8'h22, 8'h00, 3'd3, {md(16'h0023), md(16'h0022)});
  endtask

  task automatic t_ignored;
    run_noaddr("R9 LDA (zp)", 1, 8'hB2, 3'd5);
    run_noaddr("R9 JMP (abs)", 1, 8'h6C, 3'd5);
    run_noaddr("R9 INX", 1, 8'hE8, 3'd0);
    run_noaddr("R9 LDA imm", 0, 8'hA9, 3'd6);
    run_noaddr("R9 ORA (zp,X)", 1, 8'h01, 3'd5);
    run_addr("R3 after ignored", 0, 8'h65, 1, 8'h44, 8'h00, 3'd1, 16'h0044);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_zero_page;
    t_absolute;
    t_double_prefix;
    t_ignored;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule